// File: doc/BRIEF.md
# Dual-Line Interrupt Hub with Reload Timer

The hub collects six interrupt sources and presents them on two request lines: a normal request (`irqOut`) and a fast request (`firqOut`). Five sources arrive as strobes from neighbouring logic. The sixth is an internal countdown timer. The timer has a 12-bit reload value and runs either from a line-rate tick input or from a divided copy of the core clock.

Software programs two source masks, one for each request line. A source may be routed to either line or to both. Each line also has a global enable. The two mask addresses are write-only. A read of either address returns the latched sources that are enabled for that line, and the same read clears those latches. A pending event can therefore be seen only once.

The register port is a simple single-cycle bus. Writes take effect at the clock edge. Read data is combinational while `busRd` is high, and the clear takes effect at the same edge.

Top module: `irq_hub`

## Requirements
- R1: Register offsets on `busAddr` are as follows:
  - 0: bit 5 is the global normal-line enable and bit 4 is the global fast-line enable.
  - 1: bit 5 selects the timer tick (1 = fast divided clock, 0 = `lineTick`).
  - 2: normal-line mask, bits 5..0.
  - 3: fast-line mask, bits 5..0.
  - 4: timer reload bits 11..8, taken from data bits 3..0.
  - 5: timer reload bits 7..0.
  A read of offsets 0, 1, 4 and 5 returns 0x00.
- R2: Status bit 5 is the timer. Status bits 4..0 follow `srcIn[4:0]` in the same positions: 4 horizontal border, 3 vertical border, 2 serial input, 1 key press, 0 cartridge.
- R3: A read of offset 2 returns {2'b00, status AND normal mask} and clears exactly those bits. Offset 3 does the same with the fast mask. A repeated read with no new event returns 0x00. A written mask value is never read back.
- R4: A status bit is set on a rising edge of its `srcIn` bit, and only if that bit is set in at least one mask at that edge. A level held high latches once. An edge that arrives while the bit is enabled in neither mask is lost, even if a mask is set later.
- R5: `irqOut` equals the global normal-line enable AND the OR of (status AND normal mask). `firqOut` is formed the same way from the fast-line enable and the fast mask.
- R6: With the fast tick selected and reload N≠0, the timer status bit is set FAST_DIV·N+1 cycles after the edge that wrote the reload. It then sets again every FAST_DIV·N cycles, because the count reloads by itself.
- R7: With the line tick selected, the count drops once per cycle in which `lineTick` is high. The Nth such cycle sets the timer status bit one cycle later.
- R8: A reload value of zero stops the timer, and no timer event occurs while it stays zero.
- R9: A write to offset 4 or 5 restarts both the count and the fast-clock divider from the new reload value.
- R10: After reset all registers and status bits are zero, both request lines are low and `busRdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Register offset |
| busWr | input | 1 | Write strobe for one cycle |
| busRd | input | 1 | Read strobe for one cycle; clears status at the edge |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid while `busRd` is high |
| lineTick | input | 1 | Line-rate tick, high one cycle per count |
| srcIn | input | 5 | External source strobes, bits 4..0 |
| irqOut | output | 1 | Normal interrupt request, active high |
| firqOut | output | 1 | Fast interrupt request, active high |

## Verification
The bench builds the hub with FAST_DIV = 3 and TMR_W = 12. One fast count then lasts three cycles, so the exact arrival cycle of a timer event can be measured for small reloads (15 to 19 cycles). The restart and periodic cases stay within a few dozen cycles.

The full 12-bit reload path is still written through both offsets. Random mask, enable and source patterns cover overlapping routing, where a read of one line clears bits that the other line shares.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int N_SRC = 6;
  localparam int TMR_SRC = 5;

  localparam int OFS_CTL0 = 0;
  localparam int OFS_CTL1 = 1;
  localparam int OFS_IRQM = 2;
  localparam int OFS_FIRQM = 3;
  localparam int OFS_RLDHI = 4;
  localparam int OFS_RLDLO = 5;

  typedef struct packed {
    logic wrIrqMask;
    logic wrFirqMask;
    logic rdIrqStat;
    logic rdFirqStat;
  } hubStrobes_t;
endpackage

// File: rtl/irq_hub_ctrl.sv
module irq_hub_ctrl
  import irq_hub_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [1:0]        wdCfg,
  output hubStrobes_t       strb,
  output logic              wrRldHi,
  output logic              wrRldLo,
  output logic              gIrqEn,
  output logic              gFirqEn,
  output logic              fastSel
);
  logic hitCtl0, hitCtl1, hitIrqM, hitFirqM, hitHi, hitLo;

  assign hitCtl0  = (busAddr == ADDR_W'(OFS_CTL0));
  assign hitCtl1  = (busAddr == ADDR_W'(OFS_CTL1));
  assign hitIrqM  = (busAddr == ADDR_W'(OFS_IRQM));
  assign hitFirqM = (busAddr == ADDR_W'(OFS_FIRQM));
  assign hitHi    = (busAddr == ADDR_W'(OFS_RLDHI));
  assign hitLo    = (busAddr == ADDR_W'(OFS_RLDLO));

  always_comb begin
    strb.wrIrqMask  = busWr & hitIrqM;
    strb.wrFirqMask = busWr & hitFirqM;
    strb.rdIrqStat  = busRd & hitIrqM;
    strb.rdFirqStat = busRd & hitFirqM;
    wrRldHi         = busWr & hitHi;
    wrRldLo         = busWr & hitLo;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gIrqEn  <= 1'b0;
      gFirqEn <= 1'b0;
      fastSel <= 1'b0;
    end else if (busWr) begin
      if (hitCtl0) begin
        gIrqEn  <= wdCfg[1];
        gFirqEn <= wdCfg[0];
      end
      if (hitCtl1) fastSel <= wdCfg[1];
    end
  end

  // R1: at most one register action per cycle
  assert_strobe_onehot_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrIrqMask, strb.wrFirqMask, strb.rdIrqStat, strb.rdFirqStat, wrRldHi, wrRldLo}));
endmodule

// File: rtl/irq_hub_timer.sv
module irq_hub_timer #(
  parameter int TMR_W    = 12,
  parameter int FAST_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrRldHi,
  input  logic       wrRldLo,
  input  logic [7:0] wData,
  input  logic       fastSel,
  input  logic       lineTick,
  output logic       tmrEvt
);
  localparam int HI_W  = TMR_W - 8;
  localparam int PRE_W = (FAST_DIV > 1) ? $clog2(FAST_DIV) : 1;

  logic [TMR_W-1:0] reloadVal, reloadNext, cnt;
  logic fastTick, tick, rldWr;

  assign rldWr = wrRldHi | wrRldLo;

  generate
    if (FAST_DIV == 1) begin : g_nodiv
      assign fastTick = 1'b1;
    end else begin : g_div
      logic [PRE_W-1:0] pre;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pre <= '0;
        else if (rldWr) pre <= '0;
        else if (pre == PRE_W'(FAST_DIV - 1)) pre <= '0;
        else pre <= pre + 1'b1;
      end
      assign fastTick = (pre == PRE_W'(FAST_DIV - 1));
    end
  endgenerate

  assign tick = fastSel ? fastTick : lineTick;

  always_comb begin
    reloadNext = reloadVal;
    if (wrRldHi) reloadNext[TMR_W-1:8] = wData[HI_W-1:0];
    if (wrRldLo) reloadNext[7:0] = wData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadVal <= '0;
      cnt       <= '0;
      tmrEvt    <= 1'b0;
    end else if (rldWr) begin
      reloadVal <= reloadNext;
      cnt       <= reloadNext;
      tmrEvt    <= 1'b0;
    end else begin
      tmrEvt <= 1'b0;
      if (tick && reloadVal != '0) begin
        if (cnt <= TMR_W'(1)) begin
          cnt    <= reloadVal;
          tmrEvt <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R6: the count never exceeds the reload value
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= reloadVal);

  // R8: a zero reload produces no event
  assert_stopped_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reloadVal == '0 && !rldWr) |=> !tmrEvt);
endmodule

// File: rtl/irq_hub_status.sv
module irq_hub_status
  import irq_hub_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  hubStrobes_t      strb,
  input  logic [N_SRC-1:0] maskData,
  input  logic [N_SRC-2:0] srcIn,
  input  logic             tmrEvt,
  input  logic             gIrqEn,
  input  logic             gFirqEn,
  output logic [N_SRC-1:0] irqView,
  output logic [N_SRC-1:0] firqView,
  output logic             irqOut,
  output logic             firqOut
);
  logic [N_SRC-1:0] irqMask, firqMask, armed, evt, setBits, clrBits, stat;
  logic [N_SRC-2:0] srcPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqMask  <= '0;
      firqMask <= '0;
      srcPrev  <= '0;
    end else begin
      srcPrev <= srcIn;
      if (strb.wrIrqMask)  irqMask  <= maskData;
      if (strb.wrFirqMask) firqMask <= maskData;
    end
  end

  assign armed   = irqMask | firqMask;
  assign evt     = {tmrEvt, srcIn & ~srcPrev};
  assign setBits = evt & armed;
  assign clrBits = (strb.rdIrqStat ? irqMask : '0) | (strb.rdFirqStat ? firqMask : '0);

  generate
    for (genvar i = 0; i < N_SRC; i++) begin : g_latch
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stat[i] <= 1'b0;
        else if (setBits[i]) stat[i] <= 1'b1;
        else if (clrBits[i]) stat[i] <= 1'b0;
      end
    end
  endgenerate

  assign irqView  = stat & irqMask;
  assign firqView = stat & firqMask;
  assign irqOut   = gIrqEn & (|irqView);
  assign firqOut  = gFirqEn & (|firqView);

  // R3: a normal-line status read without a new event leaves nothing visible
  assert_rd_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdIrqStat && setBits == '0) |=> ((stat & irqMask) == '0));

  // R4: a bit enabled in neither mask never becomes newly set
  assert_latch_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((stat & ~$past(stat) & ~$past(armed)) == '0));
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int TMR_W    = 12,
  parameter int FAST_DIV = 4,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic              lineTick,
  input  logic [N_SRC-2:0]  srcIn,
  output logic              irqOut,
  output logic              firqOut
);
  hubStrobes_t strb;
  logic wrRldHi, wrRldLo, gIrqEn, gFirqEn, fastSel, tmrEvt;
  logic [N_SRC-1:0] irqView, firqView;

  irq_hub_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .wdCfg(busWdata[5:4]), .strb(strb), .wrRldHi(wrRldHi), .wrRldLo(wrRldLo),
    .gIrqEn(gIrqEn), .gFirqEn(gFirqEn), .fastSel(fastSel)
  );

  irq_hub_timer #(.TMR_W(TMR_W), .FAST_DIV(FAST_DIV)) u_timer (
    .clk(clk), .rstN(rstN), .wrRldHi(wrRldHi), .wrRldLo(wrRldLo),
    .wData(busWdata), .fastSel(fastSel), .lineTick(lineTick), .tmrEvt(tmrEvt)
  );

  irq_hub_status u_status (
    .clk(clk), .rstN(rstN), .strb(strb), .maskData(busWdata[N_SRC-1:0]),
    .srcIn(srcIn), .tmrEvt(tmrEvt), .gIrqEn(gIrqEn), .gFirqEn(gFirqEn),
    .irqView(irqView), .firqView(firqView), .irqOut(irqOut), .firqOut(firqOut)
  );

  always_comb begin
    busRdata = '0;
    if (strb.rdIrqStat) busRdata = 8'(irqView);
    else if (strb.rdFirqStat) busRdata = 8'(firqView);
  end

  // R5: a request line is never raised while its global enable is off
  assert_irq_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> gIrqEn);
  assert_firq_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    firqOut |-> gFirqEn);
endmodule

// File: tb/irq_hub_tb.sv
module irq_hub_tb;
  localparam int FDIV = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] busAddr = '0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic lineTick = 1'b0;
  logic [4:0] srcIn = '0;
  logic irqOut, firqOut;

  int cyc = 0;
  int nRun = 0, nFail = 0;
  bit done = 0;

  irq_hub #(.TMR_W(12), .FAST_DIV(FDIV), .ADDR_W(4)) u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .lineTick(lineTick),
    .srcIn(srcIn), .irqOut(irqOut), .firqOut(firqOut)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk); busRd = 1'b0;
  endtask

  task automatic pulseSrc(input logic [4:0] p);
    @(negedge clk); srcIn = p;
    @(negedge clk); srcIn = '0;
  endtask

  task automatic pulseLine();
    @(negedge clk); lineTick = 1'b1;
    @(negedge clk); lineTick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitIrq(output int at);
    int guard = 0;
    while (!irqOut && guard < 500) begin @(negedge clk); guard++; end
    at = cyc;
  endtask

  function automatic int expRead(input int stat, input int mask);
    return stat & mask & 8'h3F;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int w, r1, r2;
    int unsigned seedv;
    seedv = $urandom(1234);

    idle(3);
    check("R10 irq at reset", irqOut, 0);
    check("R10 firq at reset", firqOut, 0);
    check("R10 rdata at reset", busRdata, 0);
    rstN = 1'b1;
    idle(2);
    rd(4'd2, d); check("R10 status after reset", d, 0);

    // R1: masks are write-only, other offsets read zero
    wr(4'd2, 8'h3F); wr(4'd3, 8'h3F);
    rd(4'd2, d); check("R1 irq mask not readable", d, 0);
    rd(4'd3, d); check("R1 firq mask not readable", d, 0);
    wr(4'd0, 8'h30);
    rd(4'd0, d); check("R1 ctl0 reads zero", d, 0);
    rd(4'd4, d); check("R1 reload hi reads zero", d, 0);

    // R2/R3/R5 directed: cartridge on normal line only
    wr(4'd3, 8'h00); wr(4'd2, 8'h3F);
    pulseSrc(5'h01); idle(1);
    check("R5 irq raised", irqOut, 1);
    check("R5 firq stays low", firqOut, 0);
    rd(4'd2, d); check("R2 cartridge bit0", d, 8'h01);
    check("R3 irq drops after read", irqOut, 0);
    rd(4'd2, d); check("R3 second read empty", d, 0);

    // R4: held level latches once
    @(negedge clk); srcIn = 5'h02;
    idle(2);
    rd(4'd2, d); check("R4 level latched", d, 8'h02);
    idle(5);
    rd(4'd2, d); check("R4 held level not relatched", d, 0);
    @(negedge clk); srcIn = '0;

    // R4: edge lost when disarmed
    wr(4'd2, 8'h00);
    pulseSrc(5'h04);
    wr(4'd2, 8'h3F);
    rd(4'd2, d); check("R4 disarmed edge lost", d, 0);
    check("R4 irq low after disarmed edge", irqOut, 0);

    // R5: global enable gates output
    wr(4'd0, 8'h00); wr(4'd2, 8'h01);
    pulseSrc(5'h01); idle(1);
    check("R5 gated by global enable", irqOut, 0);
    wr(4'd0, 8'h20);
    check("R5 enable releases pending", irqOut, 1);
    rd(4'd2, d);

    // Random routing patterns (timer stopped, reload zero)
    for (int it = 0; it < 40; it++) begin
      int im, fm, g, pat;
      im  = $urandom % 64;
      fm  = $urandom % 64;
      g   = $urandom % 4;
      pat = $urandom % 32;
      wr(4'd2, 8'h3F); wr(4'd3, 8'h3F);
      rd(4'd2, d); rd(4'd3, d);
      wr(4'd2, 8'(im)); wr(4'd3, 8'(fm)); wr(4'd0, 8'(g << 4));
      pulseSrc(5'(pat)); idle(1);
      check("R5 random irq", irqOut, ((g >> 1) & 1) & int'(expRead(pat, im) != 0));
      check("R5 random firq", firqOut, (g & 1) & int'(expRead(pat, fm) != 0));
      rd(4'd2, d); check("R3 random irq read", d, expRead(pat, im));
      rd(4'd3, d); check("R3 random firq read shared clear", d, expRead(pat & ~im, fm));
      rd(4'd2, d); check("R3 random reread", d, 0);
    end

    // R6: fast tick timing and periodic reload
    wr(4'd1, 8'h20); wr(4'd3, 8'h00); wr(4'd2, 8'h20); wr(4'd0, 8'h20);
    rd(4'd2, d);
    wr(4'd4, 8'h00);
    wr(4'd5, 8'h05); w = cyc;
    waitIrq(r1);
    check("R6 first timer event delay", r1 - w, 5 * FDIV + 1);
    rd(4'd2, d); check("R2 timer at bit5", d, 8'h20);
    waitIrq(r2);
    check("R6 periodic reload interval", r2 - r1, 5 * FDIV);
    rd(4'd2, d);

    // R9: rewrite restarts the count
    wr(4'd5, 8'h06); w = cyc;
    idle(10);
    check("R9 no event before restart period", irqOut, 0);
    waitIrq(r1);
    check("R9 restart delay", r1 - w, 6 * FDIV + 1);
    rd(4'd2, d);

    // R7: line-rate ticks
    wr(4'd1, 8'h00);
    wr(4'd5, 8'h03);
    rd(4'd2, d);
    pulseLine(); pulseLine(); idle(3);
    check("R7 two line ticks no event", irqOut, 0);
    pulseLine();
    check("R7 event one cycle after tick", irqOut, 0);
    idle(1);
    check("R7 third line tick fires", irqOut, 1);
    rd(4'd2, d); check("R7 timer status", d, 8'h20);

    // R8: zero reload stops the timer
    wr(4'd4, 8'h00); wr(4'd5, 8'h00);
    rd(4'd2, d);
    wr(4'd1, 8'h20);
    idle(100);
    check("R8 stopped timer silent", irqOut, 0);
    rd(4'd2, d); check("R8 no timer status", d, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule